// File: doc/BRIEF.md
# Cache Miss Cause Classifier

This block watches a stream of memory block numbers, as seen by a cache model with a fixed organisation. Each access is tagged as a hit or as a miss, and every miss gets a cause. A cold miss is the first reference to a block. A conflict miss is a block lost to set contention. A capacity miss is a block that even a cache with free placement would not have held. The cache under test is set associative with a parameterised number of ways. One way gives a direct-mapped cache, and as many ways as blocks gives a fully associative one. The set is the block number modulo the number of sets, and the ways of a set are replaced least recently used first.

To find the cause of a miss, the block keeps three structures, all updated on the same strobe. The first holds the tags of the cache under test. The second is a shadow fully associative LRU cache with the same total block count. The third is a bounded first-touch history of block numbers. The result code appears one cycle after the strobe. Four running counters, one per result class, move in the same cycle as the code. The sum of the three miss counters is the total miss count.

Top module: `miss_classifier`

## Requirements
- R1: A result strobe `res_vld_o` is high exactly in the cycle after a cycle with `acc_vld_i` high, and low otherwise.
- R2: Result codes are 2'b00 hit, 2'b01 cold, 2'b10 conflict, 2'b11 capacity; the code reads 2'b00 whenever `res_vld_o` is low.
- R3: A miss on a block number absent from the first-touch history, while the history is not full, is cold, in any cache organisation.
- R4: A miss on a block already seen that hits in the shadow fully associative LRU cache of NUM_BLOCKS entries is a conflict.
- R5: A miss on a block already seen that also misses in the shadow cache is a capacity miss.
- R6: The cache under test maps a block to set (block mod NUM_BLOCKS/WAYS) and replaces the least recently used way of that set. With 4 blocks, the pattern 0,4,0,4,0,4,0,4 gives 2 cold and 6 conflict results when WAYS=1, and 2 cold and 6 hits when WAYS=2.
- R7: After reset all counters are zero and `hist_full_o` is low. Each result adds one to exactly the counter of its class, visible in the cycle the code appears. Counters do not change in cycles without a result.
- R8: The history records up to HIST_DEPTH distinct block numbers. `hist_full_o` rises in the cycle after the last slot is filled and stays high. Block numbers that arrive after that are not recorded, and once full no result is cold.
- R9: The shadow cache evicts its least recently used entry, and a hit refreshes an entry's recency.
- R10: An access whose block is held in its set of the cache under test yields the hit code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld_i | input | 1 | Access strobe |
| acc_blk_i | input | BLK_W | Block number of the access |
| res_vld_o | output | 1 | Result strobe, one cycle after the access |
| res_code_o | output | 2 | Result class code |
| n_hit_o | output | CNT_W | Hit count |
| n_cold_o | output | CNT_W | Cold miss count |
| n_conf_o | output | CNT_W | Conflict miss count |
| n_cap_o | output | CNT_W | Capacity miss count |
| hist_full_o | output | 1 | First-touch history saturated |

## Verification
A wrong tag or recency in the cache under test shows up at the next access to that set. It appears as a hit reported as conflict, or the reverse. A stale recency order in the shadow cache swaps conflict and capacity on the first reuse of the evicted block. That can lie several accesses later, so the bench replays eviction chains built to reach that point. A history error turns a cold code into another code at once, and after saturation it shows as a cold code that should not appear. The counters give a running cross-check that exposes any misrouted increment at the next total.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
    typedef enum logic [1:0] {
        CODE_HIT  = 2'b00,
        CODE_COLD = 2'b01,
        CODE_CONF = 2'b10,
        CODE_CAP  = 2'b11
    } acc_code_e;
endpackage

// File: rtl/mcc_lru_ways.sv
// One group of WAYS entries with true LRU ordering kept as distinct ages.
module mcc_lru_ways #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_i,
    input  logic [TAG_W-1:0] tag_i,
    output logic             hit_o
);
    localparam int AGE_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    typedef struct packed {
        logic [WAYS-1:0]            vld;
        logic [WAYS-1:0][TAG_W-1:0] tag;
        logic [WAYS-1:0][AGE_W-1:0] age;
    } way_state_t;

    way_state_t      st_q, st_d;
    logic [WAYS-1:0] match;
    logic [AGE_W-1:0] hit_idx, inv_idx, old_idx, touch;
    logic            any_inv;

    always_comb begin
        hit_idx = '0;
        inv_idx = '0;
        old_idx = '0;
        any_inv = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            match[w] = st_q.vld[w] && (st_q.tag[w] == tag_i);
            if (match[w]) hit_idx = AGE_W'(w);
            if (!st_q.vld[w]) begin
                inv_idx = AGE_W'(w);
                any_inv = 1'b1;
            end
            if (st_q.age[w] == AGE_W'(WAYS - 1)) old_idx = AGE_W'(w);
        end
        hit_o = |match;
        touch = hit_o ? hit_idx : (any_inv ? inv_idx : old_idx);

        st_d = st_q;
        if (upd_i) begin
            for (int w = 0; w < WAYS; w++) begin
                if (st_q.age[w] < st_q.age[touch]) st_d.age[w] = st_q.age[w] + AGE_W'(1);
            end
            st_d.age[touch] = '0;
            st_d.vld[touch] = 1'b1;
            st_d.tag[touch] = tag_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.vld <= '0;
            st_q.tag <= '0;
            for (int w = 0; w < WAYS; w++) st_q.age[w] <= AGE_W'(w);
        end else begin
            st_q <= st_d;
        end
    end

    // R9: LRU fill never leaves two entries with the same tag
    assert_single_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/mcc_history.sv
// Bounded first-touch record of block numbers.
module mcc_history #(
    parameter int BLK_W = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_i,
    input  logic [BLK_W-1:0] blk_i,
    output logic             seen_o,
    output logic             full_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][BLK_W-1:0] ent;
        logic [CNT_W-1:0]            cnt;
    } hist_state_t;

    hist_state_t st_q, st_d;

    always_comb begin
        seen_o = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if ((CNT_W'(i) < st_q.cnt) && (st_q.ent[i] == blk_i)) seen_o = 1'b1;
        end
        full_o = (st_q.cnt == CNT_W'(DEPTH));

        st_d = st_q;
        if (upd_i && !seen_o && !full_o) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CNT_W'(i) == st_q.cnt) st_d.ent[i] = blk_i;
            end
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_full_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |=> full_o);
    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));
endmodule

// File: rtl/mcc_cut_store.sv
// Tag store of the cache under test: NUM_SETS groups of WAYS entries.
module mcc_cut_store #(
    parameter int BLK_W      = 8,
    parameter int NUM_BLOCKS = 4,
    parameter int WAYS       = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_i,
    input  logic [BLK_W-1:0] blk_i,
    output logic             hit_o
);
    localparam int NUM_SETS = NUM_BLOCKS / WAYS;
    localparam int SET_BITS = $clog2(NUM_SETS);
    localparam int TAG_W    = BLK_W - SET_BITS;
    localparam int SEL_W    = (SET_BITS > 0) ? SET_BITS : 1;

    logic [BLK_W-1:0]    quot;
    logic [TAG_W-1:0]    tag;
    logic [SEL_W-1:0]    set_sel;
    logic [NUM_SETS-1:0] set_hit;

    always_comb begin
        quot    = blk_i / BLK_W'(NUM_SETS);
        tag     = quot[TAG_W-1:0];
        set_sel = SEL_W'(blk_i % BLK_W'(NUM_SETS));
        hit_o   = set_hit[set_sel];
    end

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        mcc_lru_ways #(.WAYS(WAYS), .TAG_W(TAG_W)) u_set (
            .clk   (clk),
            .rst_n (rst_n),
            .upd_i (upd_i && (set_sel == SEL_W'(s))),
            .tag_i (tag),
            .hit_o (set_hit[s])
        );
    end
endmodule

// File: rtl/miss_classifier.sv
module miss_classifier
    import mcc_pkg::*;
#(
    parameter int BLK_W      = 8,
    parameter int NUM_BLOCKS = 4,
    parameter int WAYS       = 1,
    parameter int HIST_DEPTH = 16,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_vld_i,
    input  logic [BLK_W-1:0] acc_blk_i,
    output logic             res_vld_o,
    output logic [1:0]       res_code_o,
    output logic [CNT_W-1:0] n_hit_o,
    output logic [CNT_W-1:0] n_cold_o,
    output logic [CNT_W-1:0] n_conf_o,
    output logic [CNT_W-1:0] n_cap_o,
    output logic             hist_full_o
);
    typedef struct packed {
        logic             vld;
        acc_code_e        code;
        logic [CNT_W-1:0] n_hit;
        logic [CNT_W-1:0] n_cold;
        logic [CNT_W-1:0] n_conf;
        logic [CNT_W-1:0] n_cap;
    } top_state_t;

    top_state_t st_q, st_d;
    logic       cut_hit, fa_hit, seen;
    acc_code_e  code;

    mcc_cut_store #(.BLK_W(BLK_W), .NUM_BLOCKS(NUM_BLOCKS), .WAYS(WAYS)) u_cut (
        .clk(clk), .rst_n(rst_n), .upd_i(acc_vld_i), .blk_i(acc_blk_i), .hit_o(cut_hit)
    );

    mcc_lru_ways #(.WAYS(NUM_BLOCKS), .TAG_W(BLK_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .upd_i(acc_vld_i), .tag_i(acc_blk_i), .hit_o(fa_hit)
    );

    mcc_history #(.BLK_W(BLK_W), .DEPTH(HIST_DEPTH)) u_hist (
        .clk(clk), .rst_n(rst_n), .upd_i(acc_vld_i), .blk_i(acc_blk_i),
        .seen_o(seen), .full_o(hist_full_o)
    );

    always_comb begin
        if (cut_hit)                     code = CODE_HIT;
        else if (!seen && !hist_full_o)  code = CODE_COLD;
        else if (fa_hit)                 code = CODE_CONF;
        else                             code = CODE_CAP;

        st_d      = st_q;
        st_d.vld  = acc_vld_i;
        st_d.code = acc_vld_i ? code : CODE_HIT;
        if (acc_vld_i) begin
            unique case (code)
                CODE_HIT:  st_d.n_hit  = st_q.n_hit  + CNT_W'(1);
                CODE_COLD: st_d.n_cold = st_q.n_cold + CNT_W'(1);
                CODE_CONF: st_d.n_conf = st_q.n_conf + CNT_W'(1);
                CODE_CAP:  st_d.n_cap  = st_q.n_cap  + CNT_W'(1);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_vld_o  = st_q.vld;
    assign res_code_o = st_q.code;
    assign n_hit_o    = st_q.n_hit;
    assign n_cold_o   = st_q.n_cold;
    assign n_conf_o   = st_q.n_conf;
    assign n_cap_o    = st_q.n_cap;

    assert_result_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_vld_i |=> res_vld_o);
    assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_vld_i |=> !res_vld_o);
    assert_idle_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld_o |-> (res_code_o == 2'b00));
    assert_counters_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_vld_i |=> ($stable(n_hit_o) && $stable(n_cold_o) && $stable(n_conf_o) && $stable(n_cap_o)));
    assert_first_touch_cold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld_i && !cut_hit && !seen && !hist_full_o) |=> (res_code_o == 2'b01));
    assert_set_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld_i && cut_hit) |=> (res_code_o == 2'b00));
    assert_no_cold_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hist_full_o |=> (res_code_o != 2'b01));
endmodule

// File: tb/miss_classifier_tb.sv
module miss_classifier_tb_top;
    localparam int BLK_W = 8;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acc_vld_i = 1'b0;
    logic [BLK_W-1:0] acc_blk_i = '0;

    logic             dm_vld, sa_vld, dm_full, sa_full;
    logic [1:0]       dm_code, sa_code;
    logic [CNT_W-1:0] dm_hit, dm_cold, dm_conf, dm_cap;
    logic [CNT_W-1:0] sa_hit, sa_cold, sa_conf, sa_cap;

    int n_tests = 0;
    int n_fail  = 0;

    logic [1:0] q_dm[$];
    logic [1:0] q_sa[$];
    string      q_req[$];

    localparam logic [1:0] H = 2'b00, C = 2'b01, F = 2'b10, P = 2'b11;

    always #4 clk = ~clk;

    miss_classifier #(.BLK_W(BLK_W), .NUM_BLOCKS(4), .WAYS(1), .HIST_DEPTH(8), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_vld_i(acc_vld_i), .acc_blk_i(acc_blk_i),
        .res_vld_o(dm_vld), .res_code_o(dm_code), .n_hit_o(dm_hit), .n_cold_o(dm_cold),
        .n_conf_o(dm_conf), .n_cap_o(dm_cap), .hist_full_o(dm_full)
    );

    miss_classifier #(.BLK_W(BLK_W), .NUM_BLOCKS(4), .WAYS(2), .HIST_DEPTH(8), .CNT_W(CNT_W)) dut_sa_i (
        .clk(clk), .rst_n(rst_n), .acc_vld_i(acc_vld_i), .acc_blk_i(acc_blk_i),
        .res_vld_o(sa_vld), .res_code_o(sa_code), .n_hit_o(sa_hit), .n_cold_o(sa_cold),
        .n_conf_o(sa_conf), .n_cap_o(sa_cap), .hist_full_o(sa_full)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic access(input int blk, input logic [1:0] e_dm, input logic [1:0] e_sa, input string req);
        @(negedge clk);
        acc_vld_i = 1'b1;
        acc_blk_i = BLK_W'(blk);
        q_dm.push_back(e_dm);
        q_sa.push_back(e_sa);
        q_req.push_back(req);
    endtask

    task automatic idle();
        @(negedge clk);
        acc_vld_i = 1'b0;
    endtask

    task automatic totals(input string req, input int dh, input int dc, input int df, input int dp,
                          input int sh, input int sc, input int sf, input int sp);
        check({req, " dm hit"}, int'(dm_hit), dh);
        check({req, " dm cold"}, int'(dm_cold), dc);
        check({req, " dm conflict"}, int'(dm_conf), df);
        check({req, " dm capacity"}, int'(dm_cap), dp);
        check({req, " 2way hit"}, int'(sa_hit), sh);
        check({req, " 2way cold"}, int'(sa_cold), sc);
        check({req, " 2way conflict"}, int'(sa_conf), sf);
        check({req, " 2way capacity"}, int'(sa_cap), sp);
    endtask

    // Monitor: pop the expected codes as each result appears
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            check("R1 strobes agree", int'(dm_vld), int'(sa_vld));
            if (dm_vld) begin
                if (q_dm.size() == 0) begin
                    check("R1 unexpected result", 1, 0);
                end else begin
                    automatic string r = q_req.pop_front();
                    check({r, " dm code"}, int'(dm_code), int'(q_dm.pop_front()));
                    check({r, " 2way code"}, int'(sa_code), int'(q_sa.pop_front()));
                end
            end else begin
                check("R2 idle code dm", int'(dm_code), 0);
                check("R2 idle code 2way", int'(sa_code), 0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        totals("R7 reset", 0, 0, 0, 0, 0, 0, 0, 0);
        check("R7 reset res_vld", int'(dm_vld), 0);
        check("R8 reset full", int'(dm_full), 0);

        // R6 / R3 / R4: ping-pong between two blocks of set 0
        access(0, C, C, "R3");
        access(4, C, C, "R3");
        for (int i = 0; i < 3; i++) begin
            access(0, F, H, "R6 R4");
            access(4, F, H, "R6 R4");
        end
        idle();
        totals("R6", 0, 2, 6, 0, 6, 2, 0, 0);

        // R7: idle cycles leave counters unchanged
        repeat (3) idle();
        totals("R7 idle", 0, 2, 6, 0, 6, 2, 0, 0);

        // R9 / R5: push block 0 out of the shadow cache
        access(8, C, C, "R3");
        access(12, C, C, "R3");
        access(16, C, C, "R3");
        access(0, P, P, "R9 R5");
        // R10 hits, new block, shadow hit
        access(0, H, H, "R10");
        access(1, C, C, "R3");
        access(1, H, H, "R10");
        access(12, F, F, "R4 R9");
        idle();
        totals("R7 mid", 2, 6, 7, 1, 8, 6, 1, 1);

        // R8 history saturation (depth 8)
        access(2, C, C, "R3");
        idle();
        check("R8 not yet full", int'(dm_full), 0);
        access(3, C, C, "R3");
        idle();
        check("R8 full dm", int'(dm_full), 1);
        check("R8 full 2way", int'(sa_full), 1);
        access(5, P, P, "R8 R5");
        access(5, H, H, "R10");
        access(9, P, P, "R8");
        idle();
        idle();
        check("R8 stays full", int'(dm_full), 1);
        totals("R7 final", 3, 8, 7, 3, 9, 8, 1, 3);
        check("R1 queue drained", q_dm.size(), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule